// File: doc/BRIEF.md
# Programmable Beep Tone Generator

This block produces a square-wave beep for an audio path. The tone is derived from a sample-rate tick: each tick moves the tone phase on by one step. A beep is a sequence of bursts. In each burst the tone sounds for a programmable ON interval and is then held low for a programmable OFF interval. The burst repeats a programmable number of extra times, and then the generator stops.

A start pulse accepted while idle captures the frequency code, both interval codes and the repeat count. The running beep then ignores those inputs until it finishes. Interval codes count in steps of `TICKS_PER_STEP` sample ticks; the default of 384 ticks is 8 ms at a 48 kHz sample rate. The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain control or status level, and there is no back-pressure to manage.

Top module: `beep_tone_gen`

## Requirements
- R1: While reset is held, and whenever the generator is idle, `busy` is 0 and `tone_out` is 0.
- R2: A `start` pulse sampled while idle makes `busy` 1 one clock later. `tone_out` is also 1 in that first cycle, because each burst opens with the high half of the tone.
- R3: During an ON interval, `tone_out` is a 50 % square wave whose period in sample ticks is set by `freq_sel`: code 0 gives 12, code 1 gives 16, code 2 gives 24 and code 3 gives 48. The high half comes first.
- R4: The ON interval lasts (`on_time` + 1) × `TICKS_PER_STEP` sample ticks.
- R5: The OFF interval lasts (`off_time` + 1) × `TICKS_PER_STEP` sample ticks, and `tone_out` is 0 throughout it.
- R6: A repeat count of N gives exactly N + 1 ON/OFF bursts. A count of 0 gives one burst. `busy` falls on the tick that ends the last OFF interval.
- R7: A `start` pulse while `busy` is 1 is ignored: the running beep neither restarts nor changes.
- R8: Only clock edges with `tick` = 1 advance the generator. Without a tick, `tone_out` and `busy` hold their values.
- R9: `freq_sel`, `on_time`, `off_time` and `repeat_cnt` are captured when a start is accepted. Later changes to them have no effect on the running beep.
- R10: Every ON interval, including each repeat, restarts the tone at the beginning of its high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-rate enable, one clock wide per sample |
| start | input | 1 | Start request, acted on only while idle |
| freq_sel | input | 2 | Tone period select (12/16/24/48 ticks) |
| on_time | input | 8 | ON interval code, (code+1) steps |
| off_time | input | 8 | OFF interval code, (code+1) steps |
| repeat_cnt | input | 7 | Number of extra bursts after the first |
| tone_out | output | 1 | Square-wave beep output |
| busy | output | 1 | High from the accepted start to the end of the last OFF interval |

## Verification
`busy` and the first high tone level are due one clock after the edge that accepts a start. After that, every output change is due one clock after the edge that carried a tick, so the expected value at tick count k is a closed-form function of the ON and OFF lengths, the tone period and the burst index. The bench drives inputs and samples outputs on the falling edge. It keeps its own tick count, which does not advance on stalled edges, and compares every cycle of each beep against that function. It also checks that `busy` is low at exactly the tick count (N+1)·(ON+OFF).

// File: rtl/beep_pkg.sv
package beep_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2
  } beep_phase_e;
endpackage

// File: rtl/beep_tone_div.sv
module beep_tone_div #(
  parameter int PER0 = 12,
  parameter int PER1 = 16,
  parameter int PER2 = 24,
  parameter int PER3 = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       adv,
  input  logic [1:0] sel,
  output logic       tone
);
  localparam int PMAX01 = (PER0 > PER1) ? PER0 : PER1;
  localparam int PMAX23 = (PER2 > PER3) ? PER2 : PER3;
  localparam int PMAX   = (PMAX01 > PMAX23) ? PMAX01 : PMAX23;
  localparam int CW     = $clog2(PMAX);

  logic [CW-1:0] per_m1;
  logic [CW-1:0] half;
  logic [CW-1:0] cnt;

  always_comb begin
    case (sel)
      2'd0:    begin per_m1 = CW'(PER0 - 1); half = CW'(PER0 / 2); end
      2'd1:    begin per_m1 = CW'(PER1 - 1); half = CW'(PER1 / 2); end
      2'd2:    begin per_m1 = CW'(PER2 - 1); half = CW'(PER2 / 2); end
      default: begin per_m1 = CW'(PER3 - 1); half = CW'(PER3 / 2); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (adv) cnt <= (cnt == per_m1) ? '0 : cnt + 1'b1;
  end

  assign tone = (cnt < half);
endmodule

// File: rtl/beep_interval_timer.sv
module beep_interval_timer #(
  parameter int STEP   = 384,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic              adv,
  input  logic [CODE_W-1:0] code,
  output logic              done
);
  localparam int SW = (STEP > 1) ? $clog2(STEP) : 1;

  logic [SW-1:0]     sub;
  logic [CODE_W-1:0] steps;
  logic              last_sub;

  assign last_sub = (sub == SW'(STEP - 1));
  assign done     = run && adv && last_sub && (steps == code);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || done) begin
      sub   <= '0;
      steps <= '0;
    end else if (run && adv) begin
      if (last_sub) begin
        sub   <= '0;
        steps <= steps + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/beep_seq_ctrl.sv
module beep_seq_ctrl
  import beep_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int REP_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        freq_in,
  input  logic [CODE_W-1:0] on_in,
  input  logic [CODE_W-1:0] off_in,
  input  logic [REP_W-1:0]  rep_in,
  input  logic              interval_done,
  output beep_phase_e       phase,
  output logic [1:0]        freq_q,
  output logic [CODE_W-1:0] code_sel,
  output logic              accept,
  output logic              tone_restart
);
  logic [CODE_W-1:0] on_q;
  logic [CODE_W-1:0] off_q;
  logic [REP_W-1:0]  rep_q;

  assign accept       = start && (phase == PH_IDLE);
  assign tone_restart = accept || (interval_done && (phase == PH_OFF));
  assign code_sel     = (phase == PH_OFF) ? off_q : on_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      freq_q <= '0;
      on_q   <= '0;
      off_q  <= '0;
      rep_q  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          phase  <= PH_ON;
          freq_q <= freq_in;
          on_q   <= on_in;
          off_q  <= off_in;
          rep_q  <= rep_in;
        end
        PH_ON: if (interval_done) phase <= PH_OFF;
        PH_OFF: if (interval_done) begin
          if (rep_q == '0) phase <= PH_IDLE;
          else begin
            phase <= PH_ON;
            rep_q <= rep_q - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen
  import beep_pkg::*;
#(
  parameter int TICKS_PER_STEP = 384,
  parameter int CODE_W         = 8,
  parameter int REP_W          = 7,
  parameter int TONE_PER0      = 12,
  parameter int TONE_PER1      = 16,
  parameter int TONE_PER2      = 24,
  parameter int TONE_PER3      = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [1:0]        freq_sel,
  input  logic [CODE_W-1:0] on_time,
  input  logic [CODE_W-1:0] off_time,
  input  logic [REP_W-1:0]  repeat_cnt,
  output logic              tone_out,
  output logic              busy
);
  beep_phase_e       phase;
  logic [1:0]        freq_q;
  logic [CODE_W-1:0] code_sel;
  logic              accept;
  logic              tone_restart;
  logic              interval_done;
  logic              tone_raw;
  logic              running;

  assign running = (phase != PH_IDLE);

  beep_seq_ctrl #(.CODE_W(CODE_W), .REP_W(REP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .freq_in(freq_sel), .on_in(on_time), .off_in(off_time), .rep_in(repeat_cnt),
    .interval_done(interval_done), .phase(phase), .freq_q(freq_q),
    .code_sel(code_sel), .accept(accept), .tone_restart(tone_restart)
  );

  beep_interval_timer #(.STEP(TICKS_PER_STEP), .CODE_W(CODE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(accept), .run(running), .adv(tick),
    .code(code_sel), .done(interval_done)
  );

  beep_tone_div #(.PER0(TONE_PER0), .PER1(TONE_PER1), .PER2(TONE_PER2), .PER3(TONE_PER3)) u_div (
    .clk(clk), .rst_n(rst_n), .clear(tone_restart), .adv(tick && (phase == PH_ON)),
    .sel(freq_q), .tone(tone_raw)
  );

  assign tone_out = (phase == PH_ON) && tone_raw;
  assign busy     = running;
endmodule

// File: rtl/beep_tone_gen_chk.sv
module beep_tone_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic start,
  input logic tone_out,
  input logic busy
);
  // R1 / R5: no tone without an active beep
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tone_out);

  // R2: accepted start gives busy and high tone on the next cycle
  p_start_opens_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && tone_out));

  // R8: nothing moves without a tick, except an accepted start
  p_hold_without_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(start && !busy)) |=> ($stable(tone_out) && $stable(busy)));

  // R6: busy ends only on a tick edge
  p_end_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick));
endmodule

bind beep_tone_gen beep_tone_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
  .tone_out(tone_out), .busy(busy)
);

// File: tb/beep_tone_gen_test.sv
module beep_tone_gen_test;
  localparam int STEP = 384;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       start = 1'b0;
  logic [1:0] freq_sel = '0;
  logic [7:0] on_time = '0;
  logic [7:0] off_time = '0;
  logic [6:0] repeat_cnt = '0;
  logic       tone_out;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  beep_tone_gen uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .freq_sel(freq_sel), .on_time(on_time), .off_time(off_time),
    .repeat_cnt(repeat_cnt), .tone_out(tone_out), .busy(busy)
  );

  // {freq, on, off, repeat, expected busy length in ticks}
  localparam logic [40:0] VEC [4] = '{
    {2'd0, 8'd0, 8'd0, 7'd0, 16'd768},
    {2'd1, 8'd1, 8'd0, 7'd1, 16'd2304},
    {2'd2, 8'd0, 8'd2, 7'd2, 16'd4608},
    {2'd3, 8'd2, 8'd1, 7'd0, 16'd1920}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tone_period(input logic [1:0] f);
    case (f)
      2'd0: return 12;
      2'd1: return 16;
      2'd2: return 24;
      default: return 48;
    endcase
  endfunction

  task automatic run_burst(input logic [1:0] f, input logic [7:0] on, input logic [7:0] off,
                           input logic [6:0] rep, input int exp_total,
                           input int stall_at, input int poke_at);
    int per = tone_period(f);
    int lon = (on + 1) * STEP;
    int loff = (off + 1) * STEP;
    int total = (rep + 1) * (lon + loff);
    int k = 0;
    int bad_on = 0, bad_off = 0, bad_busy = 0, bad_stall = 0;
    int a_on = 0, e_on = 0;
    check(total == exp_total, "R6 burst length table", total, exp_total);
    freq_sel = f; on_time = on; off_time = off; repeat_cnt = rep;
    start = 1'b1; tick = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: scramble settings after the start is accepted
    freq_sel = ~f; on_time = ~on; off_time = ~off; repeat_cnt = ~rep;
    check(busy === 1'b1 && tone_out === 1'b1, "R2 first cycle busy&tone", {busy, tone_out}, 3);
    forever begin
      int pos = k % (lon + loff);
      logic eb = (k < total);
      logic et = eb && (pos < lon) && ((pos % per) < per / 2);
      if (busy !== eb) bad_busy++;
      if (eb && pos < lon) begin
        if (tone_out !== et) begin
          if (bad_on == 0) begin a_on = tone_out; e_on = et; end
          bad_on++;
        end
      end else if (tone_out !== 1'b0) bad_off++;
      if (k == total) break;
      if (k == stall_at) begin
        tick = 1'b0;
        repeat (40) begin
          @(negedge clk);
          if (busy !== eb || tone_out !== et) bad_stall++;
        end
        tick = 1'b1;
      end
      if (k == poke_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k++;
    end
    check(bad_on == 0, "R3 R4 R10 ON tone waveform", a_on, e_on);
    check(bad_off == 0, "R5 OFF/idle silence mismatches", bad_off, 0);
    check(bad_busy == 0, "R6 R9 busy window mismatches", bad_busy, 0);
    if (stall_at >= 0) check(bad_stall == 0, "R8 stall hold mismatches", bad_stall, 0);
    if (poke_at >= 0) check(bad_busy == 0 && bad_on == 0, "R7 start while busy ignored", bad_busy + bad_on, 0);
    check(busy === 1'b0 && tone_out === 1'b0, "R6 idle after last OFF", {busy, tone_out}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && tone_out === 1'b0, "R1 outputs during reset", {busy, tone_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && tone_out === 1'b0, "R1 idle after reset", {busy, tone_out}, 0);

    for (int i = 0; i < 4; i++) begin
      logic [40:0] v = VEC[i];
      run_burst(v[40:39], v[38:31], v[30:23], v[22:16], int'(v[15:0]), -1, -1);
      @(negedge clk);
    end

    // R7: start pulse in the middle of a beep
    run_burst(2'd1, 8'd0, 8'd0, 7'd0, 768, -1, 300);
    @(negedge clk);
    // R8: tick stalled inside an ON interval and at the ON/OFF seam
    run_burst(2'd0, 8'd0, 8'd0, 7'd1, 1536, 100, -1);
    run_burst(2'd2, 8'd0, 8'd0, 7'd0, 768, 383, -1);

    // R1: reset in the middle of a beep returns to idle
    freq_sel = 2'd0; on_time = 8'd3; off_time = 8'd3; repeat_cnt = 7'd5;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && tone_out === 1'b0, "R1 reset mid-beep", {busy, tone_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: a fresh start right after reset
    run_burst(2'd3, 8'd0, 8'd0, 7'd0, 768, -1, -1);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule